// File: doc/BRIEF.md
# Nine-Bit Word Byte Packer

This block sits between a command/pixel source and a serial engine that can only shift whole bytes. Each item it takes in becomes a 9-bit word made of a data/command flag and eight data bits. Eight such words are joined most significant bit first into a 72-bit group and sent out as exactly nine bytes. A receiver that reads the stream in 9-bit units then recovers the flag and the byte of every word.

A command always ends a group. If the group is not full yet, no-op words (flag 0, data 0x00) are inserted in front of the command until it takes the eighth slot. A data run ends with a beat that has the last marker. If the run does not end on a group boundary, no-op words fill the rest of the group. A data beat can also carry one 16-bit pixel, which is split into two words with the high byte first. The output is a byte stream with valid/ready handshaking. A last flag marks the ninth byte of the group that closes a transfer.

Top module: `nine_bit_packer`

## Requirements
- R1: After reset, `out_valid_o` is low.
- R2: Each 9-bit word is the flag bit followed by its 8 data bits. A group of eight words is sent as nine bytes, most significant bit first. The first byte of a data group is therefore 1 followed by bits 7..1 of the first data byte.
- R3: A padding word has flag 0 and data 0x00.
- R4: A command beat (`in_dc_i`=0) is placed in the eighth slot of a group. If the group is still open, no-op words fill every slot before the command.
- R5: A data beat with `in_last_i` that leaves a group partly filled causes no-op words to fill that group to its end.
- R6: A data beat with `in_wide_i`=1 gives two words: `in_data_i[15:8]` first, then `in_data_i[7:0]`. With `in_wide_i`=0 it gives one word from `in_data_i[7:0]`.
- R7: The number of output bytes is always a multiple of nine. `out_last_o` is high only on the ninth byte of a group whose final word came from a beat marked last.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` and `out_last_o` hold their values.
- R9: A command beat always uses `in_data_i[7:0]` as one word, and `in_wide_i` has no effect on it.
- R10: A data beat without `in_last_i` leaves the group open. The next beats continue in the same group with no padding in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted this cycle |
| in_data_i | input | 16 | Beat payload (low byte, or pixel when wide) |
| in_dc_i | input | 1 | 1 = data, 0 = command |
| in_wide_i | input | 1 | Data beat carries a 16-bit pixel |
| in_last_i | input | 1 | Beat closes the transfer |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Sink accepts the output byte |
| out_data_o | output | 8 | Packed output byte |
| out_last_o | output | 1 | Ninth byte of the closing group |

## Verification
The assertions check three things on every cycle. First, a stalled output byte and a stalled internal word stay stable. Second, the leftover bit count never goes past one byte. Third, a last-flagged byte only ever falls on the ninth position of a group, and a command is only taken into the final slot. Only the bench scenarios can show that the bit pattern is correct. They compare whole groups against a bit-level model for single commands, full and partial data runs, wide pixels, commands that close open data, and a stalling sink.

// File: rtl/nwp_pkg.sv
package nwp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = BYTE_W + 1;
  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic {F_RUN, F_PAD} feed_state_e;
endpackage

// File: rtl/nwp_feeder.sv
module nwp_feeder
  import nwp_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [2*BW-1:0] in_data_i,
  input  logic          in_dc_i,
  input  logic          in_wide_i,
  input  logic          in_last_i,
  output logic          w_valid_o,
  input  logic          w_ready_i,
  output logic [BW:0]   w_word_o,
  output logic          w_end_o
);
  localparam int SW = $clog2(BW);
  localparam logic [SW-1:0] SLOT_END = SW'(BW - 1);

  feed_state_e     st_q;
  logic [SW-1:0]   slot_q;
  logic            half_q;
  logic            take;

  always_comb begin
    w_valid_o = 1'b0;
    w_word_o  = '0;
    w_end_o   = 1'b0;
    take      = 1'b0;
    if (st_q == F_PAD) begin
      w_valid_o = 1'b1;
      w_end_o   = (slot_q == SLOT_END);
    end else if (in_valid_i) begin
      w_valid_o = 1'b1;
      if (!in_dc_i) begin
        // command waits for the final slot, pads go out first
        if (slot_q == SLOT_END) begin
          w_word_o = {1'b0, in_data_i[BW-1:0]};
          take     = 1'b1;
          w_end_o  = in_last_i;
        end
      end else begin
        take     = !in_wide_i || half_q;
        w_word_o = {1'b1, (in_wide_i && !half_q) ? in_data_i[2*BW-1:BW] : in_data_i[BW-1:0]};
        w_end_o  = take && in_last_i && (slot_q == SLOT_END);
      end
    end
  end

  assign in_ready_o = (st_q == F_RUN) && w_ready_i && take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_RUN;
      slot_q <= '0;
      half_q <= 1'b0;
    end else if (w_valid_o && w_ready_i) begin
      slot_q <= slot_q + 1'b1;
      if (st_q == F_PAD) begin
        if (slot_q == SLOT_END) st_q <= F_RUN;
      end else if (in_dc_i) begin
        half_q <= !take;
        if (take && in_last_i && slot_q != SLOT_END) st_q <= F_PAD;
      end
    end
  end

  // R4
  cmd_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !in_dc_i) |-> (slot_q == SLOT_END));

  // R8
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_valid_o && !w_ready_i) |=> (w_valid_o && $stable(w_word_o)));
endmodule

// File: rtl/nwp_packer.sv
module nwp_packer #(
  parameter int BW = nwp_pkg::BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          w_valid_i,
  output logic          w_ready_o,
  input  logic [BW:0]   w_word_i,
  input  logic          w_end_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [BW-1:0] out_data_o,
  output logic          out_last_o
);
  localparam int CW = $clog2(BW + 1);

  logic [CW-1:0]   cnt_q;
  logic [BW-1:0]   rem_q;
  logic            end_q;
  logic            slot_free;
  logic            flush;
  logic [CW-1:0]   shamt;
  logic [2*BW-1:0] merged;

  assign slot_free = !out_valid_o || out_ready_i;
  assign flush     = (cnt_q == CW'(BW));
  assign w_ready_o = slot_free && !flush;
  assign shamt     = CW'(BW - 1) - cnt_q;

  // leftover bits left-aligned on top, new word placed just below them
  always_comb merged = {rem_q, {BW{1'b0}}} | ({{(BW-1){1'b0}}, w_word_i} << shamt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      rem_q       <= '0;
      end_q       <= 1'b0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
    end else begin
      if (out_valid_o && out_ready_i) out_valid_o <= 1'b0;
      if (flush && slot_free) begin
        out_valid_o <= 1'b1;
        out_data_o  <= rem_q;
        out_last_o  <= end_q;
        cnt_q       <= '0;
        rem_q       <= '0;
      end else if (w_valid_i && w_ready_o) begin
        out_valid_o <= 1'b1;
        out_data_o  <= merged[2*BW-1:BW];
        out_last_o  <= 1'b0;
        rem_q       <= merged[BW-1:0];
        cnt_q       <= cnt_q + 1'b1;
        end_q       <= w_end_i;
      end
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  // R7
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(BW));
endmodule

// File: rtl/nine_bit_packer.sv
module nine_bit_packer
  import nwp_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [2*BW-1:0] in_data_i,
  input  logic          in_dc_i,
  input  logic          in_wide_i,
  input  logic          in_last_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [BW-1:0] out_data_o,
  output logic          out_last_o
);
  localparam int BIW = $clog2(BW + 1);

  logic        w_valid;
  logic        w_ready;
  logic [BW:0] w_word;
  logic        w_end;

  nwp_feeder #(.BW(BW)) u_feed (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_data_i, .in_dc_i,
    .in_wide_i, .in_last_i,
    .w_valid_o(w_valid), .w_ready_i(w_ready), .w_word_o(w_word), .w_end_o(w_end)
  );

  nwp_packer #(.BW(BW)) u_pack (
    .clk_i, .rst_ni,
    .w_valid_i(w_valid), .w_ready_o(w_ready), .w_word_i(w_word), .w_end_i(w_end),
    .out_valid_o, .out_ready_i, .out_data_o, .out_last_o
  );

  // byte position within the output group, for checking only
  logic [BIW-1:0] bidx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bidx_q <= '0;
    else if (out_valid_o && out_ready_i)
      bidx_q <= (bidx_q == BIW'(BW)) ? '0 : bidx_q + 1'b1;
  end

  // R7
  last_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_last_o) |-> (bidx_q == BIW'(BW)));
endmodule

// File: tb/sim_nine_bit_packer.sv
`timescale 1ns/1ps
module sim_nine_bit_packer;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_dc = 0, in_wide = 0, in_last = 0, out_ready = 0;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  nine_bit_packer u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_dc_i(in_dc), .in_wide_i(in_wide), .in_last_i(in_last),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_last_o(out_last)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] bd [0:63];
  logic bdc [0:63], bwide [0:63], blast [0:63];
  int nb;
  logic [8:0] ew [0:255];
  int nw;
  logic [7:0] eb [0:287], gb [0:287];
  int ne, ng;
  bit got_last;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_beat(input logic [15:0] d, input bit dc, input bit wd, input bit lst);
    bd[nb] = d; bdc[nb] = dc; bwide[nb] = wd; blast[nb] = lst; nb++;
  endtask

  task automatic model();
    int slot = 0;
    nw = 0;
    for (int i = 0; i < nb; i++) begin
      if (!bdc[i]) begin
        while (slot != 7) begin ew[nw] = 9'h000; nw++; slot++; end
        ew[nw] = {1'b0, bd[i][7:0]}; nw++; slot = 0;
      end else begin
        if (bwide[i]) begin ew[nw] = {1'b1, bd[i][15:8]}; nw++; slot = (slot + 1) % 8; end
        ew[nw] = {1'b1, bd[i][7:0]}; nw++; slot = (slot + 1) % 8;
        if (blast[i]) while (slot != 0) begin ew[nw] = 9'h000; nw++; slot = (slot + 1) % 8; end
      end
    end
    ne = 0;
    for (int g = 0; g < nw / 8; g++) begin
      logic [71:0] blk;
      for (int k = 0; k < 8; k++) blk[71 - 9*k -: 9] = ew[8*g + k];
      for (int j = 0; j < 9; j++) begin eb[ne] = blk[71 - 8*j -: 8]; ne++; end
    end
  endtask

  task automatic drive();
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      in_valid = 1; in_data = bd[i]; in_dc = bdc[i]; in_wide = bwide[i]; in_last = blast[i];
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  task automatic collect(input bit bp);
    int cyc = 0;
    ng = 0; got_last = 0;
    while (!got_last) begin
      @(negedge clk);
      out_ready = bp ? (cyc % 3 != 1) : 1'b1;
      cyc++;
      #1;
      if (out_valid && out_ready) begin
        if (ng < 288) gb[ng] = out_data;
        ng++;
        got_last = out_last;
      end
    end
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic run_case(input string req, input bit bp);
    model();
    fork
      drive();
      collect(bp);
    join
    check(ng == ne, {req, " byte count"}, ng, ne);
    check(ng % 9 == 0, "R7 multiple of nine", ng % 9, 0);
    for (int j = 0; j < ne && j < ng; j++)
      check(gb[j] == eb[j], req, gb[j], eb[j]);
    nb = 0;
  endtask

  // R1
  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 idle out_valid", out_valid, 0);
  endtask

  // R4 R3: lone command -> eight zero bytes then the command byte
  task automatic t_cmd();
    nb = 0;
    add_beat(16'h002C, 0, 0, 1);
    run_case("R4 lone command", 0);
    check(gb[0] == 8'h00 && gb[8] == 8'h2C, "R3 pad and cmd position", {gb[0], gb[8]}, 16'h002C);
  endtask

  // R2 full data group
  task automatic t_data8();
    for (int i = 0; i < 8; i++) add_beat(16'(8'hA5 ^ (i * 8'h13)), 1, 0, i == 7);
    run_case("R2 full data group", 0);
    check(gb[0] == {1'b1, 7'(8'hA5 >> 1)}, "R2 first byte", gb[0], {1'b1, 7'(8'hA5 >> 1)});
  endtask

  // R5 partial run
  task automatic t_partial();
    add_beat(16'h00FF, 1, 0, 0);
    add_beat(16'h0081, 1, 0, 0);
    add_beat(16'h0042, 1, 0, 1);
    run_case("R5 partial data pad", 0);
  endtask

  // R6 wide pixels
  task automatic t_wide();
    add_beat(16'hF800, 1, 1, 0);
    add_beat(16'h07E0, 1, 1, 0);
    add_beat(16'h001F, 1, 1, 0);
    add_beat(16'h1234, 1, 1, 1);
    run_case("R6 wide pixel order", 0);
    check(gb[0] == 8'hFC, "R6 high byte first", gb[0], 8'hFC);
  endtask

  // R10 R4: open data then command closes group; command without last then data
  task automatic t_mixed();
    add_beat(16'h0011, 1, 0, 0);
    add_beat(16'h0022, 1, 0, 0);
    add_beat(16'h0033, 1, 0, 0);
    add_beat(16'h002A, 0, 0, 0);
    for (int i = 0; i < 10; i++) add_beat(16'(i * 7 + 1), 1, 0, i == 9);
    run_case("R10 open group then command", 0);
  endtask

  // R9 command ignores wide
  task automatic t_cmd_wide();
    add_beat(16'hAB2B, 0, 1, 1);
    run_case("R9 command wide ignored", 0);
    check(gb[8] == 8'h2B, "R9 command low byte", gb[8], 8'h2B);
  endtask

  // R8 R7 back-pressure over a long mixed run
  task automatic t_stall();
    add_beat(16'h0036, 0, 0, 0);
    for (int i = 0; i < 12; i++) add_beat(16'(16'h9C31 * (i + 1)), 1, 1, 0);
    add_beat(16'h0077, 1, 0, 1);
    run_case("R8 stalled sink", 1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    nb = 0;
    t_reset();
    t_cmd();
    t_data8();
    t_partial();
    t_wide();
    t_mixed();
    t_cmd_wide();
    t_stall();
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R7 no trailing bytes", out_valid, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule